// File: doc/BRIEF.md
# Jitter-Tolerant Serial Audio Word Receiver

This block takes one channel of serial audio from a data line, a bit clock and a word clock, and delivers complete parallel samples to a core that runs on the system clock. All three serial inputs are resynchronised into the system clock domain. Data bits are shifted in, most significant bit first, on each rising edge of the bit clock. A falling edge of the word clock marks the end of a word. Words are right-justified, so the bits shifted in last before that edge are the least significant ones. The bits of a word may be sent at any point inside the word period.

A falling word clock edge only latches the finished word into a holding register. The word goes to the core when an internal phase counter reaches a fixed transfer point. That counter runs on the system clock and repeats every word period. After reset the first falling edge sets the counter's phase. Each later falling edge is compared with the counter. An edge that lands within a small tolerance of the expected boundary leaves the counter alone, so jitter on the serial clocks does not move the transfer. An edge further off reloads the counter to the boundary.

A static select input picks 24-bit words when high and 20-bit words when low. A 20-bit word is sign-extended to the full output width.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and just after it is released, `sampleOut` is 0 and `sampleValid` is 0.
- R2: After reset, no `sampleValid` pulse occurs until a falling edge of `wordClk` has been seen. The first such falling edge always sets the internal word phase, whatever the counter held before.
- R3: With `wordSel24` = 1, the output word equals the last 24 bits sampled on `bitClk` rising edges before a `wordClk` falling edge. The first of these bits lands in bit 23 and the last in bit 0.
- R4: With `wordSel24` = 0, output bits 19..0 equal the last 20 sampled bits, with the last bit in bit 0. Bits 23..20 all copy bit 19. Any bits sent earlier in the same word have no effect.
- R5: The output depends only on the order of the bits, not on where they sit in the word period. A burst at the start of the period followed by idle time gives the same word as a burst that ends at the falling edge. Extra leading bits beyond the word length are discarded.
- R6: `sampleValid` is high for exactly one system clock per transfer. `sampleOut` changes only in the cycle where `sampleValid` is high.
- R7: A word closed by a `wordClk` falling edge is presented once, in the following word period, at a fixed phase (`XFER_AT`) of the internal counter. With a steady word clock of `PERIOD` system clocks, consecutive pulses are exactly `PERIOD` cycles apart.
- R8: A falling edge that arrives up to `SLIP` system clocks early or late against the expected boundary does not move the internal timing. The pulse spacing stays `PERIOD`.
- R9: A falling edge more than `SLIP` cycles off the expected boundary reloads the internal counter. The next pulse then follows that edge with the same latency as an aligned edge, so the pulse gap equals the edge-to-edge distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitClk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| wordClk | input | 1 | Word clock; a falling edge closes a word |
| serialData | input | 1 | Serial data, MSB first, two's complement |
| wordSel24 | input | 1 | Word length select: 1 = 24 bits, 0 = 20 bits |
| sampleOut | output | 24 | Parallel sample for the core |
| sampleValid | output | 1 | One-cycle strobe marking a new `sampleOut` |

## Verification
A corrupted phase counter shows up at the ports as a pulse gap other than the word period. It can also show as a pulse that does not follow a reloading edge by the usual latency. Either appears at the very next transfer, at most one word period later. A fault in the shift or hold path shows up as a wrong `sampleOut` one word period after the falling edge that closed the word. A fault in the alignment flag shows up as a pulse before any falling edge has been driven. The directed scenarios therefore measure both the data value and the cycle gap at every pulse. They place edges both inside and outside the slip tolerance, and they leave a long idle stretch before the first edge.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  // Control-to-datapath strobes, all valid for one system clock
  typedef struct packed {
    logic shiftEn;    // a bit clock rising edge was seen
    logic serialBit;  // the resynchronised data bit for that edge
    logic capture;    // a word clock falling edge was seen
    logic transfer;   // internal phase reached the transfer point
  } sarx_strobes_t;

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/sarx_ctrl.sv
module sarx_ctrl
  import sarx_pkg::*;
#(
  parameter int PERIOD      = 128,
  parameter int XFER_AT     = 64,
  parameter int SLIP        = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PHASE_W    = $clog2(PERIOD)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitClk,
  input  logic               wordClk,
  input  logic               serialData,
  output sarx_strobes_t      stb,
  output logic [PHASE_W-1:0] phase,
  output logic               aligned
);

  localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(PERIOD - 1);
  localparam logic [PHASE_W-1:0] WIN_LO  = PHASE_W'(PERIOD - 1 - SLIP);
  localparam logic [PHASE_W-1:0] WIN_HI  = PHASE_W'(SLIP);
  localparam logic [PHASE_W-1:0] XFER_PH = PHASE_W'(XFER_AT);

  logic [2:0] syncQ;
  logic       bcPrev, wcPrev;
  logic       bcRise, wcFall, inWindow, reload;

  sarx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    ({bitClk, wordClk, serialData}),
    .q    (syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcPrev <= 1'b0;
      wcPrev <= 1'b0;
    end else begin
      bcPrev <= syncQ[2];
      wcPrev <= syncQ[1];
    end
  end

  assign bcRise = syncQ[2] & ~bcPrev;
  assign wcFall = ~syncQ[1] & wcPrev;

  // An aligned edge is seen while the phase sits on its last count;
  // the window accepts SLIP counts either side of that point.
  assign inWindow = (phase >= WIN_LO) || (phase < WIN_HI);
  assign reload   = wcFall && (!aligned || !inWindow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      aligned <= 1'b0;
    end else begin
      if (reload)              phase <= '0;
      else if (phase == LAST_PH) phase <= '0;
      else                     phase <= phase + 1'b1;
      aligned <= aligned | wcFall;
    end
  end

  always_comb begin
    stb.shiftEn   = bcRise;
    stb.serialBit = syncQ[0];
    stb.capture   = wcFall;
    stb.transfer  = aligned && (phase == XFER_PH);
  end

endmodule

// File: rtl/sarx_datapath.sv
module sarx_datapath
  import sarx_pkg::*;
#(
  parameter int WORD_MAX = 24,
  parameter int WORD_MIN = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarx_strobes_t       stb,
  input  logic                wordSel24,
  output logic [WORD_MAX-1:0] sampleOut,
  output logic                sampleValid
);

  localparam int EXT_W = WORD_MAX - WORD_MIN;

  logic [WORD_MAX-1:0] shiftReg;
  logic [WORD_MAX-1:0] holdWord;
  logic [WORD_MAX-1:0] narrowWord;

  if (EXT_W > 0) begin : g_ext
    assign narrowWord = {{EXT_W{shiftReg[WORD_MIN-1]}}, shiftReg[WORD_MIN-1:0]};
  end else begin : g_noext
    assign narrowWord = shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.shiftEn) begin
      shiftReg <= {shiftReg[WORD_MAX-2:0], stb.serialBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
    end else if (stb.capture) begin
      holdWord <= wordSel24 ? shiftReg : narrowWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= stb.transfer;
      if (stb.transfer) sampleOut <= holdWord;
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int WORD_MAX    = 24,
  parameter int WORD_MIN    = 20,
  parameter int PERIOD      = 128,
  parameter int XFER_AT     = 64,
  parameter int SLIP        = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PHASE_W    = $clog2(PERIOD)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic                serialData,
  input  logic                wordSel24,
  output logic [WORD_MAX-1:0] sampleOut,
  output logic                sampleValid
);

  sarx_strobes_t      stb;
  logic [PHASE_W-1:0] phase;
  logic               aligned;

  sarx_ctrl #(
    .PERIOD(PERIOD), .XFER_AT(XFER_AT), .SLIP(SLIP), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitClk     (bitClk),
    .wordClk    (wordClk),
    .serialData (serialData),
    .stb        (stb),
    .phase      (phase),
    .aligned    (aligned)
  );

  sarx_datapath #(.WORD_MAX(WORD_MAX), .WORD_MIN(WORD_MIN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wordSel24   (wordSel24),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker
  import sarx_pkg::*;
#(
  parameter int WORD_MAX = 24,
  parameter int PERIOD   = 128,
  localparam int PHASE_W = $clog2(PERIOD)
) (
  input logic                clk,
  input logic                rstN,
  input logic [WORD_MAX-1:0] sampleOut,
  input logic                sampleValid,
  input sarx_strobes_t       stb,
  input logic [PHASE_W-1:0]  phase,
  input logic                aligned
);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleOut));

  // R2
  no_early_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !aligned |-> !sampleValid);

  // R7
  xfer_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.transfer |=> sampleValid);

  // R2
  first_edge_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !aligned) |=> (aligned && phase == '0));

  // R7
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.capture && phase == PHASE_W'(PERIOD - 1)) |=> (phase == '0));

endmodule

bind serial_audio_rx sarx_checker #(.WORD_MAX(WORD_MAX), .PERIOD(PERIOD)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleOut   (sampleOut),
  .sampleValid (sampleValid),
  .stb         (stb),
  .phase       (phase),
  .aligned     (aligned)
);

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        wordClk = 1'b1;
  logic        serialData = 1'b0;
  logic        wordSel24 = 1'b1;
  logic [23:0] sampleOut;
  logic        sampleValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int          cyc = 0;
  int          validCount = 0;
  int          lastCyc = 0;
  int          lastGap = 0;
  logic [23:0] lastData = '0;
  bit          prevValid = 1'b0;
  bit          errPulse = 1'b0;
  bit          errHold = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  serial_audio_rx u0 (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk),
    .serialData(serialData), .wordSel24(wordSel24),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Observe outputs away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid) begin
        if (prevValid) errPulse = 1'b1;
        lastGap  = cyc - lastCyc;
        lastCyc  = cyc;
        lastData = sampleOut;
        validCount++;
      end else if (sampleOut !== lastData) begin
        errHold = 1'b1;
      end
      prevValid = sampleValid;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One word period: wordClk low for the first 64 steps (the fall at
  // step 0 closes the previous word), then high. Bits are right-aligned
  // to the end of the period unless early is set. Each bit lasts 4 clocks.
  task automatic sendFrame(input logic [31:0] bits, input int nbits,
                           input int len, input bit early);
    int start;
    start = early ? 0 : len - 4 * nbits;
    for (int step = 0; step < len; step++) begin
      int rel;
      @(negedge clk);
      wordClk = (step < 64) ? 1'b0 : 1'b1;
      rel = step - start;
      if (rel >= 0 && rel < 4 * nbits) begin
        serialData = bits[nbits - 1 - rel / 4];
        bitClk     = ((rel % 4) >= 2);
      end else begin
        bitClk = 1'b0;
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 sampleValid in reset", 32'(sampleValid), 0);
    chk("R1 sampleOut in reset", 32'(sampleOut), 0);
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 sampleOut after release", 32'(sampleOut), 0);
    repeat (300) @(negedge clk);
    chk("R2 no pulse before first fall", validCount, 0);
  endtask

  task automatic testWide();
    wordSel24 = 1'b1;
    sendFrame(32'h123456, 24, 128, 1'b0);
    chk("R2 first fall aligns, one pulse", validCount, 1);
    chk("R2 first word is the empty register", 32'(lastData), 0);
    sendFrame(32'h800001, 24, 128, 1'b0);
    chk("R3 wide word", 32'(lastData), 32'h123456);
    sendFrame(32'h7FFFFF, 24, 128, 1'b0);
    chk("R3 wide negative word", 32'(lastData), 32'h800001);
    chk("R7 steady gap", lastGap, 128);
    sendFrame(32'h000000, 24, 128, 1'b0);
    chk("R3 wide max positive", 32'(lastData), 32'h7FFFFF);
    chk("R7 one pulse per period", validCount, 4);
  endtask

  task automatic testNarrow();
    wordSel24 = 1'b0;
    sendFrame(32'hA7ABCD, 24, 128, 1'b0);
    sendFrame(32'h081234, 24, 128, 1'b0);
    chk("R4 narrow positive, top bits ignored", 32'(lastData), 32'h07ABCD);
    sendFrame(32'h00001, 20, 128, 1'b0);
    chk("R4 narrow negative sign-extended", 32'(lastData), 32'hF81234);
    sendFrame(32'h0, 20, 128, 1'b0);
    chk("R4 narrow twenty-bit burst", 32'(lastData), 32'h000001);
  endtask

  task automatic testPlacement();
    wordSel24 = 1'b1;
    sendFrame(32'hDEADBEEF, 32, 128, 1'b0);
    sendFrame(32'h345678, 24, 128, 1'b1);
    chk("R5 leading extra bits dropped", 32'(lastData), 32'hADBEEF);
    sendFrame(32'h0, 24, 128, 1'b0);
    chk("R5 early burst then idle", 32'(lastData), 32'h345678);
  endtask

  task automatic testJitter();
    sendFrame(32'h111111, 24, 128, 1'b0);
    sendFrame(32'h222222, 24, 129, 1'b0);
    chk("R8 data before late edge", 32'(lastData), 32'h111111);
    sendFrame(32'h333333, 24, 128, 1'b0);
    chk("R8 late-by-one edge keeps gap", lastGap, 128);
    chk("R8 data after late edge", 32'(lastData), 32'h222222);
    sendFrame(32'h444444, 24, 127, 1'b0);
    chk("R8 gap after late edge", lastGap, 128);
    sendFrame(32'h555555, 24, 128, 1'b0);
    chk("R8 early-by-one edge keeps gap", lastGap, 128);
    chk("R8 data after early edge", 32'(lastData), 32'h444444);
  endtask

  task automatic testRealign();
    sendFrame(32'h666666, 24, 148, 1'b0);
    chk("R9 gap before far edge", lastGap, 128);
    sendFrame(32'h777777, 24, 128, 1'b0);
    chk("R9 far-late edge reloads", lastGap, 148);
    chk("R9 data across late reload", 32'(lastData), 32'h666666);
    sendFrame(32'h888888, 24, 108, 1'b0);
    chk("R9 steady after reload", lastGap, 128);
    sendFrame(32'h999999, 24, 128, 1'b0);
    chk("R9 far-early edge reloads", lastGap, 108);
    chk("R9 data across early reload", 32'(lastData), 32'h888888);
    sendFrame(32'h0, 24, 128, 1'b0);
    chk("R7 steady after realign", lastGap, 128);
    chk("R7 data after realign", 32'(lastData), 32'h999999);
  endtask

  task automatic testPulseShape();
    chk("R6 no back-to-back strobes", 32'(errPulse), 0);
    chk("R6 output held between strobes", 32'(errHold), 0);
  endtask

  initial begin
    testReset();
    testWide();
    testNarrow();
    testPlacement();
    testJitter();
    testRealign();
    testPulseShape();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule